// File: doc/BRIEF.md
# Dual-Port Shared Byte Memory with Multiplexed-Bus Ports

This block is a 504-location, byte-wide memory shared by two processor ports that work independently of each other. Each port has the classic multiplexed bus of a small controller. An address is placed on the shared bus lines and captured by a latch strobe. The same lines then carry write data into the block. Read data comes back on a separate output byte with an output enable, and a chip-level wrapper folds it onto the pads.

Both ports live in a single clock domain. Every strobe is sampled and edge-detected on the clock. The latch strobe is honoured whether or not the port is selected. Read and write strobes only count while chip select is high. When both ports touch the same location in one clock cycle, the outcome is fixed, so no access ever sees or stores a partial byte.

All strobes are active high. The bus input is 9 bits wide: all 9 bits form the address, and bits [7:0] carry write data.

Top module: `mbr_shared_ram`

## Requirements
- R1: A port's address register loads all 9 bits of its bus input on the clock edge where the latch strobe is seen low after having been high on the previous edge. It keeps that value until the next such falling edge.
- R2: Address capture by the latch strobe happens whether the port's chip select is high or low.
- R3: A port's output enable is high only while both its read strobe and its chip select are high. While the output enable is low, the port's read-data output is all zeros.
- R4: A write takes effect on the clock edge where the write strobe is seen high after being low on the previous edge, with chip select high. It stores bus bits [7:0] present at that edge into the latched address. A rising write strobe with chip select low changes nothing.
- R5: When both ports read the same location, both return the same stored byte.
- R6: While one port commits a write to the location the other port is reading, the reader shows the complete old byte before that edge and the complete new byte after it.
- R7: If both ports commit writes to the same in-range address on the same edge, the byte from port A is stored.
- R8: Writes from both ports to different addresses on the same edge are both stored.
- R9: Addresses 504 to 511 read back as zero with the output enable still high. Writes to them change no location.
- R10: After synchronous reset, both output enables are low and both read-data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset |
| a_bus_in | input | 9 | Port A multiplexed bus: address (all bits) / write data (bits 7:0) |
| a_ale | input | 1 | Port A address latch strobe |
| a_rd | input | 1 | Port A read strobe |
| a_wr | input | 1 | Port A write strobe |
| a_cs | input | 1 | Port A chip select |
| a_bus_out | output | 8 | Port A read data |
| a_bus_oe | output | 1 | Port A read-data output enable |
| b_bus_in | input | 9 | Port B multiplexed bus: address (all bits) / write data (bits 7:0) |
| b_ale | input | 1 | Port B address latch strobe |
| b_rd | input | 1 | Port B read strobe |
| b_wr | input | 1 | Port B write strobe |
| b_cs | input | 1 | Port B chip select |
| b_bus_out | output | 8 | Port B read data |
| b_bus_oe | output | 1 | Port B read-data output enable |

## Verification
Two kinds of access can land on one location in the same cycle. The first is a write edge on one port while the other port reads that location. The second is a write edge on both ports at once. The bench latches one address into both ports, then raises the strobes on a single falling clock edge so the design sees both at the same rising edge. For a read against a write, the reader's byte is sampled just before that edge and must equal the old value. Sampled after the edge, it must equal the new value. For two writes, both ports read back afterwards, and the stored byte must be port A's for two different data pairs.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

    localparam int ADDR_W    = 9;
    localparam int DATA_W    = 8;
    localparam int MEM_DEPTH = 504;
    localparam int NUM_PORTS = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    // strobes of one port, all active high
    typedef struct packed {
        logic ale;
        logic rd;
        logic wr;
        logic cs;
    } port_ctl_t;

    // a one-cycle write request from a port front end
    typedef struct packed {
        logic  vld;
        addr_t addr;
        data_t data;
    } wr_req_t;

    function automatic logic addr_in_range(addr_t a, int depth);
        return int'(a) < depth;
    endfunction

endpackage

// File: rtl/mbr_port_front.sv
module mbr_port_front
    import mbr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  addr_t     bus_in,
    input  port_ctl_t ctl,
    input  data_t     rdata,
    output addr_t     addr,
    output wr_req_t   wreq,
    output data_t     bus_out,
    output logic      bus_oe
);

    logic  ale_q;
    logic  wr_q;
    addr_t addr_q;

    // latch strobe is edge-detected regardless of chip select
    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            wr_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_q <= ctl.ale;
            wr_q  <= ctl.wr;
            if (ale_q && !ctl.ale) begin
                addr_q <= bus_in;
            end
        end
    end

    always_comb begin
        addr      = addr_q;
        wreq.vld  = ctl.wr && !wr_q && ctl.cs;
        wreq.addr = addr_q;
        wreq.data = bus_in[DATA_W-1:0];
        bus_oe    = ctl.rd && ctl.cs;
        bus_out   = bus_oe ? rdata : '0;
    end

endmodule

// File: rtl/mbr_store.sv
module mbr_store
    import mbr_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH
) (
    input  logic    clk,
    input  wr_req_t wreq  [NUM_PORTS],
    input  addr_t   raddr [NUM_PORTS],
    output data_t   rdata [NUM_PORTS]
);

    data_t               mem [DEPTH];
    logic [NUM_PORTS-1:0] take;

    // lower port index has priority on a same-address clash
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            take[p] = wreq[p].vld && addr_in_range(wreq[p].addr, DEPTH);
            for (int q = 0; q < p; q++) begin
                if (take[q] && wreq[q].addr == wreq[p].addr) begin
                    take[p] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (take[p]) begin
                mem[wreq[p].addr] <= wreq[p].data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
            always_comb begin
                if (addr_in_range(raddr[g], DEPTH)) begin
                    rdata[g] = mem[raddr[g]];
                end else begin
                    rdata[g] = '0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/mbr_shared_ram.sv
module mbr_shared_ram
    import mbr_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [8:0] a_bus_in,
    input  logic       a_ale,
    input  logic       a_rd,
    input  logic       a_wr,
    input  logic       a_cs,
    output logic [7:0] a_bus_out,
    output logic       a_bus_oe,
    input  logic [8:0] b_bus_in,
    input  logic       b_ale,
    input  logic       b_rd,
    input  logic       b_wr,
    input  logic       b_cs,
    output logic [7:0] b_bus_out,
    output logic       b_bus_oe
);

    addr_t     bus_in_v [NUM_PORTS];
    port_ctl_t ctl_v    [NUM_PORTS];
    addr_t     addr_v   [NUM_PORTS];
    wr_req_t   wreq_v   [NUM_PORTS];
    data_t     rdata_v  [NUM_PORTS];
    data_t     out_v    [NUM_PORTS];
    logic      oe_v     [NUM_PORTS];
    addr_t     a_addr_q;
    addr_t     b_addr_q;

    assign bus_in_v[0] = a_bus_in;
    assign bus_in_v[1] = b_bus_in;
    assign ctl_v[0]    = '{ale: a_ale, rd: a_rd, wr: a_wr, cs: a_cs};
    assign ctl_v[1]    = '{ale: b_ale, rd: b_rd, wr: b_wr, cs: b_cs};
    assign a_bus_out   = out_v[0];
    assign a_bus_oe    = oe_v[0];
    assign b_bus_out   = out_v[1];
    assign b_bus_oe    = oe_v[1];
    assign a_addr_q    = addr_v[0];
    assign b_addr_q    = addr_v[1];

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
            mbr_port_front u_front (
                .clk     (clk),
                .rst     (rst),
                .bus_in  (bus_in_v[g]),
                .ctl     (ctl_v[g]),
                .rdata   (rdata_v[g]),
                .addr    (addr_v[g]),
                .wreq    (wreq_v[g]),
                .bus_out (out_v[g]),
                .bus_oe  (oe_v[g])
            );
        end
    endgenerate

    mbr_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .wreq  (wreq_v),
        .raddr (addr_v),
        .rdata (rdata_v)
    );

endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
    import mbr_pkg::*;
#(
    parameter int DEPTH = MEM_DEPTH
) (
    input logic       clk,
    input logic       rst,
    input logic [8:0] a_bus_in,
    input logic       a_ale,
    input logic       a_rd,
    input logic       a_wr,
    input logic       a_cs,
    input logic [7:0] a_bus_out,
    input logic       a_bus_oe,
    input logic [8:0] b_bus_in,
    input logic       b_ale,
    input logic       b_rd,
    input logic       b_wr,
    input logic       b_cs,
    input logic [7:0] b_bus_out,
    input logic       b_bus_oe,
    input addr_t      a_addr_q,
    input addr_t      b_addr_q
);

    logic armed;
    logic a_wr_seen;
    logic b_wr_seen;
    logic a_fire;
    logic b_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            a_wr_seen <= 1'b0;
            b_wr_seen <= 1'b0;
        end else begin
            armed     <= 1'b1;
            a_wr_seen <= a_wr;
            b_wr_seen <= b_wr;
        end
    end

    assign a_fire = a_wr && !a_wr_seen && a_cs;
    assign b_fire = b_wr && !b_wr_seen && b_cs;

    // R1
    a_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $fell(a_ale)) |=> (a_addr_q == $past(a_bus_in)));

    // R1
    b_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $fell(b_ale)) |=> (b_addr_q == $past(b_bus_in)));

    // R3
    a_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(a_rd && a_cs) |-> (!a_bus_oe && a_bus_out == '0));

    // R3
    b_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(b_rd && b_cs) |-> (!b_bus_oe && b_bus_out == '0));

    // R5
    same_read_chk: assert property (@(posedge clk) disable iff (rst)
        (a_bus_oe && b_bus_oe && a_addr_q == b_addr_q) |-> (a_bus_out == b_bus_out));

    // R9
    high_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (a_bus_oe && !addr_in_range(a_addr_q, DEPTH)) |-> (a_bus_out == '0));

    // R4
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        (a_fire && addr_in_range(a_addr_q, DEPTH)) |=>
        (!(a_bus_oe && a_addr_q == $past(a_addr_q)) || a_bus_out == $past(a_bus_in[7:0])));

    // R7
    a_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (a_fire && b_fire && a_addr_q == b_addr_q && addr_in_range(a_addr_q, DEPTH)) |=>
        (!(b_bus_oe && b_addr_q == $past(b_addr_q)) || b_bus_out == $past(a_bus_in[7:0])));

endmodule

bind mbr_shared_ram mbr_checker #(.DEPTH(DEPTH)) u_mbr_checker (
    .clk       (clk),
    .rst       (rst),
    .a_bus_in  (a_bus_in),
    .a_ale     (a_ale),
    .a_rd      (a_rd),
    .a_wr      (a_wr),
    .a_cs      (a_cs),
    .a_bus_out (a_bus_out),
    .a_bus_oe  (a_bus_oe),
    .b_bus_in  (b_bus_in),
    .b_ale     (b_ale),
    .b_rd      (b_rd),
    .b_wr      (b_wr),
    .b_cs      (b_cs),
    .b_bus_out (b_bus_out),
    .b_bus_oe  (b_bus_oe),
    .a_addr_q  (a_addr_q),
    .b_addr_q  (b_addr_q)
);

// File: tb/test_mbr_shared_ram.sv
module test_mbr_shared_ram;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] bin [2];
    logic       ale [2];
    logic       rd  [2];
    logic       wr  [2];
    logic       cs  [2];
    logic [7:0] bout [2];
    logic       boe  [2];
    int         vectors = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    mbr_shared_ram i_mbr_shared_ram (
        .clk       (clk),
        .rst       (rst),
        .a_bus_in  (bin[0]),
        .a_ale     (ale[0]),
        .a_rd      (rd[0]),
        .a_wr      (wr[0]),
        .a_cs      (cs[0]),
        .a_bus_out (bout[0]),
        .a_bus_oe  (boe[0]),
        .b_bus_in  (bin[1]),
        .b_ale     (ale[1]),
        .b_rd      (rd[1]),
        .b_wr      (wr[1]),
        .b_cs      (cs[1]),
        .b_bus_out (bout[1]),
        .b_bus_oe  (boe[1])
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        for (int p = 0; p < 2; p++) begin
            bin[p] = '0; ale[p] = 1'b0; rd[p] = 1'b0; wr[p] = 1'b0; cs[p] = 1'b0;
        end
    endtask

    // latch an address; chip select left as given
    task automatic latch(input int p, input logic [8:0] a);
        bin[p] = a; ale[p] = 1'b1;
        @(negedge clk);
        ale[p] = 1'b0;
        @(negedge clk);
        bin[p] = '0;
    endtask

    task automatic write_byte(input int p, input logic [7:0] d, input logic sel);
        bin[p] = {1'b0, d}; cs[p] = sel; wr[p] = 1'b1;
        @(negedge clk);
        wr[p] = 1'b0; cs[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_chk(input int p, input logic [7:0] exp, input string tag);
        cs[p] = 1'b1; rd[p] = 1'b1;
        #2;
        chk(tag, {7'd0, boe[p], bout[p]}, {7'd0, 1'b1, exp});
        rd[p] = 1'b0; cs[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        #2;
        chk("R10 port A oe/data after reset", {7'd0, boe[0], bout[0]}, 16'h0);
        chk("R10 port B oe/data after reset", {7'd0, boe[1], bout[1]}, 16'h0);
    endtask

    task automatic t_write_read();
        latch(0, 9'd0);   write_byte(0, 8'h3C, 1'b1); read_chk(0, 8'h3C, "R4 write/read addr 0");
        latch(1, 9'd503); write_byte(1, 8'hC3, 1'b1); read_chk(1, 8'hC3, "R4 write/read addr 503");
        latch(0, 9'd503); read_chk(0, 8'hC3, "R1 port A relatched to 503");
        read_chk(0, 8'hC3, "R1 address held without new latch");
    endtask

    task automatic t_select();
        latch(0, 9'd7); write_byte(0, 8'h81, 1'b1);
        write_byte(0, 8'hFF, 1'b0);
        read_chk(0, 8'h81, "R4 unselected write ignored");
        cs[0] = 1'b0; rd[0] = 1'b1; #2;
        chk("R3 read without select", {7'd0, boe[0], bout[0]}, 16'h0);
        cs[0] = 1'b1; rd[0] = 1'b0; #2;
        chk("R3 select without read", {7'd0, boe[0], bout[0]}, 16'h0);
        cs[0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_latch_unselected();
        latch(1, 9'd5); write_byte(1, 8'h5A, 1'b1);
        cs[0] = 1'b0;
        latch(0, 9'd5);
        read_chk(0, 8'h5A, "R2 latch with chip select low");
    endtask

    task automatic t_dual_read();
        latch(0, 9'd12); write_byte(0, 8'h96, 1'b1);
        latch(1, 9'd12);
        cs[0] = 1'b1; rd[0] = 1'b1; cs[1] = 1'b1; rd[1] = 1'b1;
        #2;
        chk("R5 port A same-location read", {8'd0, bout[0]}, 16'h0096);
        chk("R5 port B same-location read", {8'd0, bout[1]}, 16'h0096);
        rd[0] = 1'b0; rd[1] = 1'b0; cs[0] = 1'b0; cs[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_read_vs_write();
        latch(0, 9'd20); write_byte(0, 8'h11, 1'b1);
        latch(1, 9'd20);
        bin[0] = 9'h022; cs[0] = 1'b1; wr[0] = 1'b1;
        cs[1] = 1'b1; rd[1] = 1'b1;
        #2;
        chk("R6 reader before write edge", {8'd0, bout[1]}, 16'h0011);
        @(negedge clk);
        chk("R6 reader after write edge", {8'd0, bout[1]}, 16'h0022);
        wr[0] = 1'b0; cs[0] = 1'b0; rd[1] = 1'b0; cs[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_write_vs_write(input logic [7:0] da, input logic [7:0] db);
        latch(0, 9'd30); latch(1, 9'd30);
        bin[0] = {1'b0, da}; cs[0] = 1'b1; wr[0] = 1'b1;
        bin[1] = {1'b0, db}; cs[1] = 1'b1; wr[1] = 1'b1;
        @(negedge clk);
        wr[0] = 1'b0; wr[1] = 1'b0; cs[0] = 1'b0; cs[1] = 1'b0;
        @(negedge clk);
        read_chk(0, da, "R7 port A wins, read on A");
        read_chk(1, da, "R7 port A wins, read on B");
    endtask

    task automatic t_parallel_writes();
        latch(0, 9'd40); latch(1, 9'd41);
        bin[0] = 9'h0A4; cs[0] = 1'b1; wr[0] = 1'b1;
        bin[1] = 9'h0B4; cs[1] = 1'b1; wr[1] = 1'b1;
        @(negedge clk);
        wr[0] = 1'b0; wr[1] = 1'b0; cs[0] = 1'b0; cs[1] = 1'b0;
        @(negedge clk);
        read_chk(0, 8'hA4, "R8 port A write kept");
        read_chk(1, 8'hB4, "R8 port B write kept");
    endtask

    task automatic t_range();
        latch(1, 9'd248); write_byte(1, 8'h48, 1'b1);
        latch(0, 9'd504); write_byte(0, 8'h77, 1'b1);
        read_chk(0, 8'h00, "R9 read at 504");
        latch(0, 9'd511); write_byte(0, 8'h99, 1'b1);
        read_chk(0, 8'h00, "R9 read at 511");
        read_chk(1, 8'h48, "R9 high writes leave 248 intact");
        latch(1, 9'd503);
        read_chk(1, 8'hC3, "R9 high writes leave 503 intact");
    endtask

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_select();
        t_latch_unselected();
        t_dual_read();
        t_read_vs_write();
        t_write_vs_write(8'hAA, 8'hBB);
        t_write_vs_write(8'h01, 8'hFE);
        t_parallel_writes();
        t_range();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule